// File: doc/BRIEF.md
# Viterbi Path Metric Unit with Noise Monitor

This block is the add-compare-select stage of a hard- or soft-decision decoder for a rate-1/2 convolutional code with constraint length 4. The code uses generator polynomials 15 and 17 (octal), so the trellis has eight states. Each accepted input carries four 3-bit branch metrics, one for each possible 2-bit code symbol. For each of the eight states the block adds the branch metric to the accumulated metric of each of its two predecessors. It then keeps the smaller candidate and records which predecessor won. The eight decision bits and the index of the state with the lowest metric go out to a traceback stage, which is not part of this block.

The metric registers are 8 bits wide. Whenever every new metric has its top bit set, that bit is cleared in all eight metrics in the same cycle. This keeps the registers from wrapping and leaves their relative order unchanged.

A noise estimate comes from watching the metric of state 0. The 8-bit range is split into four equal bands, and the boundaries sit at multiples of 64. Each time that metric climbs past a band boundary, a counter steps up. A clean channel keeps the survivor metric nearly flat, so the counter grows slowly. A noisy channel makes it climb quickly.

Top module: `vit_pmu`

## Requirements
- R1: Synchronous active-high reset sets the metric of state 0 to 0 and every other state's metric to 64. It also clears the noise counter, `dec_valid` and `dec_bits`. After reset, `best_state` reads 0 and `best_metric` reads 0.
- R2: Trellis and input layout:
  - State `n` is reached from `{0,n[2:1]}` (lower predecessor) and from `{1,n[2:1]}` (upper predecessor), with input bit `u = n[0]`.
  - For predecessor `p`, the code symbol is `{c0,c1}`, where `c0 = u^p[0]^p[2]` and `c1 = u^p[0]^p[1]^p[2]`.
  - The branch metric for symbol value `k` is `in_bm[3k+2:3k]`.
- R3: A candidate sum never exceeds 255. When all eight newly selected metrics are 128 or more, bit 7 is cleared in all of them in the same update.
- R4: `dec_bits[n]` is 1 only when the upper predecessor's candidate is strictly smaller. On a tie it is 0.
- R5: `best_state` is the index of the smallest current metric, with ties going to the lower index. `best_metric` is that metric's value.
- R6: On each update, `noise_count` increases by the number of multiples of 64 that state 0's new metric rises past. The comparison uses the stored old value and the new value before normalization. The count wraps modulo 256.
- R7: A symbol is taken only on a clock edge where `in_valid` and `in_ready` are both high. Without that, metrics and `noise_count` hold. `dec_valid` is high in exactly the cycle after each accepted symbol.
- R8: `in_ready` is low during reset and in the first cycle after it, and high from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Branch metric word present |
| in_ready | output | 1 | Block can take a word |
| in_bm | input | 12 | Four 3-bit branch metrics, symbol k at bits 3k+2:3k |
| dec_valid | output | 1 | Decision vector valid this cycle |
| dec_bits | output | 8 | One decision bit per state, 1 = upper predecessor won |
| best_state | output | 3 | Index of the lowest-metric state |
| best_metric | output | 8 | Metric of that state |
| noise_count | output | 8 | Band-crossing count of state 0's metric |

## Verification
The hardest situation to reach is normalization. It fires only after every metric has climbed past 128, and during that climb state 0's metric crosses band boundaries both with and without a rebase. The bench reaches it by streaming long runs of symbols in which every branch metric is high, and also by a long pseudo-random stream. A bench model computes the expected decisions, best state, best metric and noise count for every symbol. Ties, the initial 0-versus-64 spread, and idle cycles with `in_valid` low are each covered by directed sequences.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int K       = 4;
    localparam int SW      = K - 1;
    localparam int NSTATE  = 1 << SW;
    localparam int BM_W    = 3;
    localparam int NSYM    = 4;
    localparam int PM_W    = 8;
    localparam int NOISE_W = 8;
    localparam int BAND_W  = 2;

    localparam logic [PM_W-1:0] PM_INIT_OTHER = 8'd64;
    localparam logic [K-1:0]    GEN_A         = 4'b1101;
    localparam logic [K-1:0]    GEN_B         = 4'b1111;

    typedef logic [PM_W-1:0]    pm_t;
    typedef logic [SW-1:0]      state_t;
    typedef logic [BM_W-1:0]    bm_t;
    typedef logic [NOISE_W-1:0] noise_t;

    typedef struct packed {
        logic dec;
        logic carry;
        pm_t  metric;
    } acs_res_t;

    function automatic state_t pred_of(state_t nxt, logic upper);
        return {upper, nxt[SW-1:1]};
    endfunction

    // Taps ordered current bit first, then oldest-last history.
    function automatic logic [1:0] code_sym(state_t pred, logic u);
        logic [K-1:0] taps;
        taps[K-1] = u;
        for (int j = 0; j < SW; j++) taps[K-2-j] = pred[j];
        return {^(taps & GEN_A), ^(taps & GEN_B)};
    endfunction
endpackage

// File: rtl/vit_acs_node.sv
module vit_acs_node
    import vit_pkg::*;
(
    input  pm_t      pm_lo,
    input  pm_t      pm_hi,
    input  bm_t      bm_lo,
    input  bm_t      bm_hi,
    output acs_res_t res
);
    logic [PM_W:0] sum_lo, sum_hi;
    logic          take_hi;

    always_comb begin
        sum_lo  = {1'b0, pm_lo} + {{(PM_W+1-BM_W){1'b0}}, bm_lo};
        sum_hi  = {1'b0, pm_hi} + {{(PM_W+1-BM_W){1'b0}}, bm_hi};
        take_hi = sum_hi < sum_lo;
        res.dec    = take_hi;
        res.carry  = sum_lo[PM_W] | sum_hi[PM_W];
        res.metric = take_hi ? sum_hi[PM_W-1:0] : sum_lo[PM_W-1:0];
    end
endmodule

// File: rtl/vit_min_tree.sv
module vit_min_tree
    import vit_pkg::*;
(
    input  pm_t    pm [NSTATE],
    output state_t best_idx,
    output pm_t    best_val
);
    pm_t    val [SW+1][NSTATE];
    state_t idx [SW+1][NSTATE];

    always_comb begin
        for (int l = 0; l <= SW; l++) begin
            for (int n = 0; n < NSTATE; n++) begin
                val[l][n] = '0;
                idx[l][n] = '0;
            end
        end
        for (int n = 0; n < NSTATE; n++) begin
            val[0][n] = pm[n];
            idx[0][n] = state_t'(n);
        end
        for (int l = 0; l < SW; l++) begin
            for (int n = 0; n < (NSTATE >> (l + 1)); n++) begin
                if (val[l][2*n+1] < val[l][2*n]) begin
                    val[l+1][n] = val[l][2*n+1];
                    idx[l+1][n] = idx[l][2*n+1];
                end else begin
                    val[l+1][n] = val[l][2*n];
                    idx[l+1][n] = idx[l][2*n];
                end
            end
        end
        best_idx = idx[SW][0];
        best_val = val[SW][0];
    end
endmodule

// File: rtl/vit_noise_mon.sv
module vit_noise_mon
    import vit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  pm_t    old_ref,
    input  pm_t    raw_ref,
    output noise_t count
);
    logic [BAND_W-1:0] band_old, band_new, steps;

    always_comb begin
        band_old = old_ref[PM_W-1 -: BAND_W];
        band_new = raw_ref[PM_W-1 -: BAND_W];
        steps    = (band_new > band_old) ? (band_new - band_old) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (take) count <= count + noise_t'(steps);
    end
endmodule

// File: rtl/vit_pmu.sv
module vit_pmu
    import vit_pkg::*;
#(
    parameter int REF_STATE = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [NSYM*BM_W-1:0]   in_bm,
    output logic                   dec_valid,
    output logic [NSTATE-1:0]      dec_bits,
    output logic [SW-1:0]          best_state,
    output logic [PM_W-1:0]        best_metric,
    output logic [NOISE_W-1:0]     noise_count
);
    pm_t               pm_q  [NSTATE];
    pm_t               raw   [NSTATE];
    bm_t               bm_arr[NSYM];
    acs_res_t          res   [NSTATE];
    logic [NSTATE-1:0] hi_bits, dec_w, carry_w;
    logic              take, norm, ready_q;

    assign in_ready = ready_q;
    assign take     = in_valid & ready_q;
    assign norm     = &hi_bits;

    genvar k, s;
    generate
        for (k = 0; k < NSYM; k++) begin : g_unpack
            assign bm_arr[k] = in_bm[k*BM_W +: BM_W];
        end
        for (s = 0; s < NSTATE; s++) begin : g_state
            localparam state_t     P_LO  = pred_of(state_t'(s), 1'b0);
            localparam state_t     P_HI  = pred_of(state_t'(s), 1'b1);
            localparam logic       U_BIT = 1'(s % 2);
            localparam logic [1:0] S_LO  = code_sym(P_LO, U_BIT);
            localparam logic [1:0] S_HI  = code_sym(P_HI, U_BIT);
            vit_acs_node u_acs (
                .pm_lo (pm_q[P_LO]),
                .pm_hi (pm_q[P_HI]),
                .bm_lo (bm_arr[S_LO]),
                .bm_hi (bm_arr[S_HI]),
                .res   (res[s])
            );
            assign raw[s]     = res[s].metric;
            assign hi_bits[s] = res[s].metric[PM_W-1];
            assign dec_w[s]   = res[s].dec;
            assign carry_w[s] = res[s].carry;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q   <= 1'b0;
            dec_valid <= 1'b0;
            dec_bits  <= '0;
            for (int i = 0; i < NSTATE; i++)
                pm_q[i] <= (i == 0) ? pm_t'(0) : PM_INIT_OTHER;
        end else begin
            ready_q   <= 1'b1;
            dec_valid <= take;
            if (take) begin
                dec_bits <= dec_w;
                for (int i = 0; i < NSTATE; i++)
                    pm_q[i] <= norm ? {1'b0, raw[i][PM_W-2:0]} : raw[i];
            end
        end
    end

    vit_min_tree u_min (
        .pm       (pm_q),
        .best_idx (best_state),
        .best_val (best_metric)
    );

    vit_noise_mon u_noise (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .old_ref (pm_q[REF_STATE]),
        .raw_ref (raw[REF_STATE]),
        .count   (noise_count)
    );
endmodule

// File: rtl/vit_pmu_chk.sv
module vit_pmu_chk
    import vit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              dec_valid,
    input logic [PM_W-1:0]   best_metric,
    input logic [NOISE_W-1:0] noise_count,
    input pm_t               pm [NSTATE],
    input logic [NSTATE-1:0] carry,
    input logic              norm
);
    logic                     take;
    logic [NSTATE-1:0]        msb;
    logic                     le_all;
    logic [NSTATE*PM_W-1:0]   flat;

    always_comb begin
        take   = in_valid & in_ready;
        le_all = 1'b1;
        for (int i = 0; i < NSTATE; i++) begin
            msb[i]              = pm[i][PM_W-1];
            flat[i*PM_W +: PM_W] = pm[i];
            if (best_metric > pm[i]) le_all = 1'b0;
        end
    end

    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        take |-> (carry == '0));
    // R3
    a_r3_norm_clears: assert property (@(posedge clk) disable iff (rst)
        (take && norm) |=> (msb == '0));
    // R5
    a_r5_best_le_all: assert property (@(posedge clk) disable iff (rst)
        le_all);
    // R7
    a_r7_metrics_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(flat));
    // R7
    a_r7_dec_valid: assert property (@(posedge clk) disable iff (rst)
        dec_valid == $past(take));
    // R6
    a_r6_noise_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(noise_count));
    // R8
    a_r8_ready_rises: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);
endmodule

bind vit_pmu vit_pmu_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .dec_valid   (dec_valid),
    .best_metric (best_metric),
    .noise_count (noise_count),
    .pm          (pm_q),
    .carry       (carry_w),
    .norm        (norm)
);

// File: tb/vit_pmu_test.sv
`timescale 1ns/1ps
module vit_pmu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_bm = '0;
    logic        dec_valid;
    logic [7:0]  dec_bits;
    logic [2:0]  best_state;
    logic [7:0]  best_metric;
    logic [7:0]  noise_count;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int mpm [8];
    int mnoise;
    int mdec;

    always #2 clk = ~clk;

    vit_pmu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_bm(in_bm), .dec_valid(dec_valid), .dec_bits(dec_bits),
        .best_state(best_state), .best_metric(best_metric),
        .noise_count(noise_count)
    );

    localparam logic [11:0] VEC [16] = '{
        12'h000, 12'h1C7, 12'hE38, 12'h249, 12'h0F3, 12'h6DB, 12'h105, 12'hA50,
        12'h7FF, 12'h3C1, 12'h018, 12'hC06, 12'h555, 12'hAAA, 12'h482, 12'h921
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) mpm[i] = (i == 0) ? 0 : 64;
        mnoise = 0;
        mdec   = 0;
    endtask

    function automatic int bm_of(logic [11:0] w, int sym);
        return int'((w >> (3*sym)) & 12'h7);
    endfunction

    function automatic int sym_of(int p, int u);
        int c0, c1;
        c0 = u ^ (p & 1) ^ ((p >> 2) & 1);
        c1 = u ^ (p & 1) ^ ((p >> 1) & 1) ^ ((p >> 2) & 1);
        return c0 * 2 + c1;
    endfunction

    task automatic model_step(logic [11:0] w);
        int nw [8];
        bit all_hi;
        mdec   = 0;
        all_hi = 1;
        for (int n = 0; n < 8; n++) begin
            int plo, phi, slo, shi;
            plo = n >> 1;
            phi = 4 + (n >> 1);
            slo = mpm[plo] + bm_of(w, sym_of(plo, n & 1));
            shi = mpm[phi] + bm_of(w, sym_of(phi, n & 1));
            if (shi < slo) begin
                nw[n] = shi;
                mdec |= (1 << n);
            end else nw[n] = slo;
            if (nw[n] < 128) all_hi = 0;
        end
        if ((nw[0] / 64) > (mpm[0] / 64))
            mnoise = (mnoise + nw[0] / 64 - mpm[0] / 64) % 256;
        for (int n = 0; n < 8; n++) mpm[n] = all_hi ? nw[n] - 128 : nw[n];
    endtask

    task automatic check_outputs(string tag);
        int bi;
        bi = 0;
        for (int n = 1; n < 8; n++) if (mpm[n] < mpm[bi]) bi = n;
        chk({tag, " R4 dec_bits"}, int'(dec_bits), mdec);
        chk({tag, " R5 best_state"}, int'(best_state), bi);
        chk({tag, " R5 best_metric"}, int'(best_metric), mpm[bi]);
        chk({tag, " R6 noise_count"}, int'(noise_count), mnoise);
    endtask

    task automatic send(logic [11:0] w, string tag);
        in_valid = 1'b1;
        in_bm    = w;
        @(posedge clk);
        model_step(w);
        @(negedge clk);
        chk({tag, " R7 dec_valid"}, int'(dec_valid), 1);
        check_outputs(tag);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst      = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 ready low in reset", int'(in_ready), 0);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lfsr;
        int          hold_metric, hold_noise;
        model_reset();
        @(negedge clk);
        do_reset();
        chk("R8 ready after reset", int'(in_ready), 1);
        chk("R1 dec_valid", int'(dec_valid), 0);
        chk("R1 dec_bits", int'(dec_bits), 0);
        chk("R1 best_state", int'(best_state), 0);
        chk("R1 best_metric", int'(best_metric), 0);
        chk("R1 noise_count", int'(noise_count), 0);

        // Table walk: R2 trellis wiring, R4 decisions, R5 best state
        for (int i = 0; i < 16; i++) send(VEC[i], "R2 table");

        // R7: idle cycles change nothing
        in_valid    = 1'b0;
        in_bm       = 12'hFFF;
        hold_metric = best_metric;
        hold_noise  = noise_count;
        repeat (3) @(negedge clk);
        chk("R7 idle dec_valid", int'(dec_valid), 0);
        chk("R7 idle best_metric", int'(best_metric), hold_metric);
        chk("R7 idle noise", int'(noise_count), hold_noise);
        send(12'h000, "R7 after idle");

        // R3, R6: high metrics drive repeated normalization and band crossings
        do_reset();
        for (int i = 0; i < 120; i++) send(12'hFFF, "R3 all-high");
        for (int i = 0; i < 60; i++) send(12'hFB6, "R3 skewed");

        // R4 tie rule from reset: all-zero metrics give zero decisions
        do_reset();
        send(12'h000, "R4 tie");
        chk("R1 init spread best_metric", int'(best_metric), 0);

        // Long pseudo-random stream with occasional idle gaps
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[11:0], "R2 random");
            if (lfsr[15:13] == 3'b000) begin
                in_valid = 1'b0;
                @(negedge clk);
                chk("R7 gap dec_valid", int'(dec_valid), 0);
            end
        end
        in_valid = 1'b0;

        // R1: reset mid-stream restores the initial state
        do_reset();
        chk("R1 re-reset best_metric", int'(best_metric), 0);
        chk("R1 re-reset noise", int'(noise_count), 0);
        chk("R1 re-reset dec_bits", int'(dec_bits), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule